// File: doc/BRIEF.md
# Serial programming command engine

This block is the target-side sequencer of a two-wire serial programming port. The serial clock drives the whole engine. A single data pin carries control codes and instruction words into the target, and carries register readback out of it. The engine reads a 4-bit control code. One code value makes it collect a 24-bit instruction and pass it to the processor as a one-cycle execute strobe. Another code value makes it return the contents of a 16-bit visibility register over the same data pin. The processor that executes the words, the flash operations and the entry into programming mode all lie outside this block. The visibility value arrives on an input port.

Execution overlaps the next fetch. The strobe for a finished instruction appears while the first bit of the following control code is being clocked in. After any reset the very first command is a stretched execute command, 9 clocks long, that carries a built-in no-op. For readback the pin turns around and becomes an output. It stays driven for half a clock after the last bit and is released at the next rising edge.

Top module: `sercmd_engine`

## Requirements
- R1: While the synchronous reset is high, busy_o is 1, exec_o is 0 and sd_oe is 0.
- R2: The first command after reset lasts 9 rising edges, and the data bits it carries are ignored. At its 4th edge it strobes an all-zero no-op word. The 24 edges that follow shift in an instruction, without any preceding control code.
- R3: A control code is 4 bits, least significant bit first. The value 0 selects execute and the value 1 selects readout.
- R4: An instruction is 24 bits, least significant bit first. instr_o shows the completed word from the edge after its 24th bit, and holds it until the next strobe.
- R5: exec_o is high for exactly one clock per executed instruction.
- R6: The strobe for an instruction coincides with the first bit of the next control code, and busy_o is 0 while a code is being fetched.
- R7: Any other code value (2 to 15) causes no strobe and no pin drive. The engine fetches a new 4-bit code straight after it.
- R8: A readout code is followed by 8 clocks with busy_o high and the pin not driven.
- R9: The 16 visibility bits then leave least significant bit first. sd_o changes on falling edges, so bit k is valid at the k-th rising edge of the data phase.
- R10: After the last bit, sd_oe stays high, holding that bit. It is released at the first rising edge of the next command.
- R11: A reset asserted in the middle of any command returns the engine to the stretched first command of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, also the engine clock |
| rst | input | 1 | Synchronous reset, active high (programming mode left) |
| sd_i | input | 1 | Data pin input value, sampled on rising edges |
| sd_o | output | 1 | Data pin output value, updated on falling edges |
| sd_oe | output | 1 | Data pin output enable |
| visi_i | input | 16 | Visibility register value for readout |
| instr_o | output | 24 | Last completed instruction word |
| exec_o | output | 1 | One-cycle execute strobe |
| busy_o | output | 1 | Low only while a control code is being fetched |

## Verification
The bench feeds the stretched first command with non-zero garbage bits. A design that decoded those bits, or counted 4 clocks instead of 9, would lose its alignment and strobe the wrong words. It sends code value 8, which a design shifting most significant bit first would take as a readout, so the pin would turn on. It runs a readout back to back with another readout, and checks that the pin stays driven for the half clock after the last bit and is released at exactly the following rising edge. A design that released the pin early, or one clock late, would fail there. A reset in the middle of an instruction must bring back the forced no-op and the 9-clock phase, or the instruction that follows arrives shifted.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [2:0] {
        PH_FORCED,   // stretched first command after reset
        PH_FETCH,    // collecting a control code
        PH_LOAD,     // collecting an instruction word
        PH_WAIT,     // idle clocks before readback
        PH_SHOUT     // readback data phase
    } phase_e;

    typedef enum logic [1:0] {
        CMD_EXEC,
        CMD_READ,
        CMD_NONE
    } cmd_e;
endpackage

// File: rtl/sercmd_code_decode.sv
module sercmd_code_decode
    import sercmd_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] code_i,
    output cmd_e              cmd_o
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        if (code_i == CODE_W'(0)) begin
            cmd_o = CMD_EXEC;
        end else if (code_i == CODE_W'(1)) begin
            cmd_o = CMD_READ;
        end else begin
            cmd_o = CMD_NONE;
        end
    end
endmodule

// File: rtl/sercmd_readout.sv
module sercmd_readout #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              sd_o,
    output logic              sd_oe
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic              oe;
    } ro_t;

    ro_t  ro_d, ro_q;
    logic out_q;
    logic oe_n_q;

    // Rising-edge side: capture, shift (last bit repeats), enable request.
    always_comb begin
        ro_d    = ro_q;
        ro_d.oe = load_i | shift_i;
        if (load_i) begin
            ro_d.sr = data_i;
        end else if (shift_i) begin
            ro_d.sr = {ro_q.sr[DATA_W-1], ro_q.sr[DATA_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ro_q <= '0;
        end else begin
            ro_q <= ro_d;
        end
    end

    // Falling-edge side: pin value and turn-on follow the falling edge.
    always_ff @(negedge clk) begin
        if (rst) begin
            out_q  <= 1'b0;
            oe_n_q <= 1'b0;
        end else begin
            out_q  <= ro_q.sr[0];
            oe_n_q <= ro_q.oe;
        end
    end

    // Turn-off follows the rising edge that clears the request.
    assign sd_o  = out_q;
    assign sd_oe = oe_n_q & ro_q.oe;
endmodule

// File: rtl/sercmd_engine.sv
module sercmd_engine
    import sercmd_pkg::*;
#(
    parameter int CODE_W      = 4,
    parameter int INSTR_W     = 24,
    parameter int DATA_W      = 16,
    parameter int WAIT_CLKS   = 8,
    parameter int FORCE_EXTRA = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sd_i,
    output logic               sd_o,
    output logic               sd_oe,
    input  logic [DATA_W-1:0]  visi_i,
    output logic [INSTR_W-1:0] instr_o,
    output logic               exec_o,
    output logic               busy_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int FORCE_LEN = CODE_W + FORCE_EXTRA;
    localparam int MAX_A     = (INSTR_W > DATA_W) ? INSTR_W : DATA_W;
    localparam int MAX_B     = (WAIT_CLKS > FORCE_LEN) ? WAIT_CLKS : FORCE_LEN;
    localparam int MAX_LEN   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W     = $clog2(MAX_LEN);

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [INSTR_W-1:0] sh;
        logic [INSTR_W-1:0] instr;
        logic               exec;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [INSTR_W-1:0] sh_next;
    cmd_e cmd;
    logic ro_load;
    logic ro_shift;

    // New bits enter at the top, so after N shifts the field is LSB-aligned in the top N bits.
    assign sh_next = {sd_i, eng_q.sh[INSTR_W-1:1]};

    sercmd_code_decode #(.CODE_W(CODE_W)) dec_i (
        .code_i (sh_next[INSTR_W-1 -: CODE_W]),
        .cmd_o  (cmd)
    );

    always_comb begin
        eng_d      = eng_q;
        eng_d.exec = 1'b0;
        ro_load    = 1'b0;
        ro_shift   = 1'b0;
        unique case (eng_q.ph)
            PH_FORCED: begin
                eng_d.cnt = eng_q.cnt + 1'b1;
                if (eng_q.cnt == CNT_W'(CODE_W - 1)) begin
                    eng_d.exec  = 1'b1;
                    eng_d.instr = '0;
                end
                if (eng_q.cnt == CNT_W'(FORCE_LEN - 1)) begin
                    eng_d.ph  = PH_LOAD;
                    eng_d.cnt = '0;
                end
            end
            PH_FETCH: begin
                eng_d.sh  = sh_next;
                eng_d.cnt = eng_q.cnt + 1'b1;
                if (eng_q.cnt == CNT_W'(CODE_W - 1)) begin
                    eng_d.cnt = '0;
                    case (cmd)
                        CMD_EXEC: eng_d.ph = PH_LOAD;
                        CMD_READ: eng_d.ph = PH_WAIT;
                        default:  eng_d.ph = PH_FETCH;
                    endcase
                end
            end
            PH_LOAD: begin
                eng_d.sh  = sh_next;
                eng_d.cnt = eng_q.cnt + 1'b1;
                if (eng_q.cnt == CNT_W'(INSTR_W - 1)) begin
                    eng_d.exec  = 1'b1;
                    eng_d.instr = sh_next;
                    eng_d.ph    = PH_FETCH;
                    eng_d.cnt   = '0;
                end
            end
            PH_WAIT: begin
                eng_d.cnt = eng_q.cnt + 1'b1;
                if (eng_q.cnt == CNT_W'(WAIT_CLKS - 1)) begin
                    ro_load   = 1'b1;
                    eng_d.ph  = PH_SHOUT;
                    eng_d.cnt = '0;
                end
            end
            PH_SHOUT: begin
                ro_shift  = 1'b1;
                eng_d.cnt = eng_q.cnt + 1'b1;
                if (eng_q.cnt == CNT_W'(DATA_W - 1)) begin
                    eng_d.ph  = PH_FETCH;
                    eng_d.cnt = '0;
                end
            end
            default: begin
                eng_d.ph  = PH_FORCED;
                eng_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_q.ph    <= PH_FORCED;
            eng_q.cnt   <= '0;
            eng_q.sh    <= '0;
            eng_q.instr <= '0;
            eng_q.exec  <= 1'b0;
        end else begin
            eng_q <= eng_d;
        end
    end

    sercmd_readout #(.DATA_W(DATA_W)) ro_i (
        .clk     (clk),
        .rst     (rst),
        .load_i  (ro_load),
        .shift_i (ro_shift),
        .data_i  (visi_i),
        .sd_o    (sd_o),
        .sd_oe   (sd_oe)
    );

    assign instr_o = eng_q.instr;
    assign exec_o  = eng_q.exec;
    assign busy_o  = (eng_q.ph != PH_FETCH);
endmodule

// File: rtl/sercmd_engine_chk.sv
module sercmd_engine_chk #(
    parameter int INSTR_W = 24
) (
    input logic               clk,
    input logic               rst,
    input logic               sd_oe,
    input logic [INSTR_W-1:0] instr_o,
    input logic               exec_o,
    input logic               busy_o
);
    timeunit 1ns;
    timeprecision 1ps;

    // R5: the strobe never lasts two clocks
    p_exec_single_r5: assert property (@(posedge clk) disable iff (rst)
        exec_o |=> !exec_o);

    // R4: the instruction bus only moves together with a strobe
    p_instr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!exec_o && !$past(rst)) |-> $stable(instr_o));

    // R8: the pin turns on only inside a readout command
    p_oe_on_busy_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(sd_oe) && !$past(rst)) |-> busy_o);

    // R9: no strobe while the pin is driven
    p_oe_no_exec_r9: assert property (@(posedge clk) disable iff (rst)
        sd_oe |-> !exec_o);

    // R10: the pin is released once the next code fetch has started
    p_oe_release_r10: assert property (@(posedge clk) disable iff (rst)
        ($fell(sd_oe) && !$past(rst)) |-> !busy_o);
endmodule

bind sercmd_engine sercmd_engine_chk #(.INSTR_W(INSTR_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .sd_oe   (sd_oe),
    .instr_o (instr_o),
    .exec_o  (exec_o),
    .busy_o  (busy_o)
);

// File: tb/sercmd_engine_tb.sv
module sercmd_engine_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sd_i = 1'b0;
    logic        sd_o;
    logic        sd_oe;
    logic [15:0] visi_i = '0;
    logic [23:0] instr_o;
    logic        exec_o;
    logic        busy_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [23:0] exp_exec_q[$];
    logic [15:0] exp_rd_q[$];

    sercmd_engine dut_i (
        .clk(clk), .rst(rst), .sd_i(sd_i), .sd_o(sd_o), .sd_oe(sd_oe),
        .visi_i(visi_i), .instr_o(instr_o), .exec_o(exec_o), .busy_o(busy_o)
    );

    always #4 clk = ~clk;  // 125 MHz

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one rising edge; returns at falling edge + 2 ns
    task automatic tick(input logic b, input bit chk_drop = 0);
        sd_i = b;
        @(posedge clk);
        if (chk_drop) begin
            #2;
            check(sd_oe == 1'b0, "R10 release at rising edge", 32'(sd_oe), 0);
        end
        @(negedge clk);
        #2;
    endtask

    task automatic send_code(input logic [3:0] c, input bit chk_drop = 0);
        for (int i = 0; i < 4; i++) tick(c[i], chk_drop && (i == 0));
    endtask

    task automatic load_word(input logic [23:0] w);
        exp_exec_q.push_back(w);
        for (int i = 0; i < 24; i++) tick(w[i]);
        // R6: strobe visible while first bit of next code is fetched
        check(exec_o == 1'b1, "R6 strobe overlaps fetch", 32'(exec_o), 1);
        check(busy_o == 1'b0, "R6 fetching after load", 32'(busy_o), 0);
    endtask

    task automatic send_exec(input logic [23:0] w, input bit chk_drop = 0);
        send_code(4'h0, chk_drop);
        load_word(w);
    endtask

    task automatic read_reg(input logic [15:0] v, input bit chk_drop = 0);
        visi_i = v;
        exp_rd_q.push_back(v);
        send_code(4'h1, chk_drop);
        for (int i = 0; i < 8; i++) begin
            tick(1'b0);
            check(busy_o == 1'b1, "R8 busy in wait", 32'(busy_o), 1);
            if (i < 7) check(sd_oe == 1'b0, "R8 pin idle in wait", 32'(sd_oe), 0);
        end
        for (int i = 0; i < 16; i++) tick(1'b0);
        check(sd_oe == 1'b1, "R10 pin held after last bit", 32'(sd_oe), 1);
        check(sd_o == v[15], "R10 last bit held", 32'(sd_o), 32'(v[15]));
    endtask

    // scoreboard monitor: execute strobes
    logic exec_prev = 1'b0;
    always @(posedge clk) begin
        #2;
        if (!rst && exec_o) begin
            check(!exec_prev, "R5 single-cycle strobe", 32'(exec_prev), 0);
            if (exp_exec_q.size() == 0) begin
                check(1'b0, "R7 unexpected strobe", 32'(instr_o), 0);
            end else begin
                logic [23:0] e;
                e = exp_exec_q.pop_front();
                check(instr_o == e, "R4 instruction word", 32'(instr_o), 32'(e));
            end
        end
        exec_prev = exec_o;
    end

    // scoreboard monitor: readback bits
    int rd_n = 0;
    logic [15:0] rd_w = '0;
    always @(negedge clk) begin
        #2;
        if (sd_oe) begin
            if (rd_n < 16) begin
                rd_w[rd_n] = sd_o;
                rd_n++;
                if (rd_n == 16) begin
                    if (exp_rd_q.size() == 0) begin
                        check(1'b0, "R9 unexpected readout", 32'(rd_w), 0);
                    end else begin
                        logic [15:0] e;
                        e = exp_rd_q.pop_front();
                        check(rd_w == e, "R9 readout word", 32'(rd_w), 32'(e));
                    end
                end
            end
        end else begin
            rd_n = 0;
        end
    end

    initial begin
        #1600000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [8:0] junk;
        junk = 9'b1_0110_1101;
        @(negedge clk);
        #2;
        for (int i = 0; i < 3; i++) tick(1'b1);
        check(busy_o == 1'b1, "R1 busy in reset", 32'(busy_o), 1);
        check(exec_o == 1'b0, "R1 no strobe in reset", 32'(exec_o), 0);
        check(sd_oe == 1'b0, "R1 pin idle in reset", 32'(sd_oe), 0);

        // R2: stretched first command with garbage bits
        rst = 1'b0;
        exp_exec_q.push_back(24'h0);
        for (int i = 0; i < 9; i++) begin
            tick(junk[i]);
            if (i == 3) check(exec_o == 1'b1 && instr_o == 24'h0, "R2 forced no-op", 32'(instr_o), 0);
        end
        check(busy_o == 1'b1, "R2 still busy after forced phase", 32'(busy_o), 1);
        load_word(24'hA5C3F0);
        check(instr_o == 24'hA5C3F0, "R2 first word after forced phase", 32'(instr_o), 32'hA5C3F0);

        send_exec(24'h000001);
        send_exec(24'h800000);

        // R7 / R3: reserved codes, including 8 (bit order check)
        send_code(4'h2);
        check(busy_o == 1'b0 && sd_oe == 1'b0, "R7 code 2 ignored", {busy_o, sd_oe}, 0);
        check(instr_o == 24'h800000, "R4 word held", 32'(instr_o), 32'h800000);
        send_code(4'hF);
        check(busy_o == 1'b0 && sd_oe == 1'b0, "R7 code 15 ignored", {busy_o, sd_oe}, 0);
        send_code(4'h8);
        check(busy_o == 1'b0 && sd_oe == 1'b0, "R3 code 8 is not readout", {busy_o, sd_oe}, 0);

        // R9 / R10 readouts, back to back
        read_reg(16'hC5A1);
        send_exec(24'hFFFFFF, 1'b1);
        read_reg(16'h8000);
        read_reg(16'h0001, 1'b1);
        send_exec(24'h5A5A5A, 1'b1);

        // R11: reset in the middle of an instruction
        send_code(4'h0);
        for (int i = 0; i < 10; i++) tick(1'b1);
        rst = 1'b1;
        tick(1'b1);
        check(busy_o == 1'b1 && exec_o == 1'b0, "R11 reset mid-command", {busy_o, exec_o}, 32'h2);
        rst = 1'b0;
        exp_exec_q.push_back(24'h0);
        for (int i = 0; i < 9; i++) tick(junk[8-i]);
        load_word(24'h123456);
        check(instr_o == 24'h123456, "R11 aligned after reset", 32'(instr_o), 32'h123456);

        tick(1'b0);
        tick(1'b0);
        check(exp_exec_q.size() == 0, "R4 all strobes seen", exp_exec_q.size(), 0);
        check(exp_rd_q.size() == 0, "R9 all readouts seen", exp_rd_q.size(), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule